// File: doc/BRIEF.md
# Real-time clock seconds, alarm and interrupt register block

This block holds the register-side state of a real-time clock whose one-second strobe is generated elsewhere. A 32-bit seconds count advances by one on each strobe. Software never writes the count directly: a new time goes into a staging register first and is copied into the live count at the next strobe. Until then the count keeps its old value. A 32-bit alarm value is compared on every strobe against the value the count is about to take. Each strobe also produces a seconds event.

The two events latch into sticky status bits that software clears by writing ones. A two-bit enable mask gates them onto two interrupt lines. The mask is never written as a whole: one register sets mask bits and another clears them. A calibration word and two control bits (battery-switch enable and oscillator enable) are stored and read back. The logic that would use them lies outside this block.

Access is through a word-addressed port: one write strobe with data, and a registered read whose data appears one cycle after the address.

Top module: `rtc_time_regs`

## Requirements
- R1: Reset is synchronous and active high. After it, the seconds count, staged time, alarm, calibration, control, status and mask are all zero, and so are both interrupt lines and the read data.
- R2: A write to word 0 (byte 0x00) stages a time value and leaves the live count unchanged. At the next strobe the live count takes the staged value. If a new staging write lands in the same cycle as a strobe, the strobe loads the older staged value and the new value waits for the following strobe.
- R3: Word 1 (byte 0x04) reads back the value most recently written to word 0.
- R4: On a strobe with no staged value pending, the count at word 4 (byte 0x10) increments by one and wraps from 0xFFFFFFFF to 0. Without a strobe it holds.
- R5: Every strobe sets status bit 0 (seconds). A strobe sets status bit 1 (alarm) when the value the count takes at that strobe equals the alarm register at word 6 (byte 0x18). The alarm register is read/write.
- R6: Status is read at word 8 (byte 0x20). Writing to that word clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. An event in the same cycle as a clear of its bit leaves the bit set.
- R7: Ones written to word 10 (byte 0x28) set the matching mask bits. Ones written to word 11 (byte 0x2C) clear them. Word 9 (byte 0x24) reads the mask in bits [1:0].
- R8: irq_sec equals status bit 0 AND mask bit 0, and irq_alarm equals status bit 1 AND mask bit 1. Each line changes on the same clock edge as the status or mask bit that drives it.
- R9: Calibration written at word 2 (byte 0x08) keeps its low 21 bits and reads back at word 3 (byte 0x0C). Control at word 16 (byte 0x40) keeps only bit 31 (battery-switch enable) and bit 24 (oscillator enable); all its other bits read 0.
- R10: Read data is registered and shows the word addressed in the previous cycle. Words 0, 2, 5, 10, 11 and unmapped words read zero. Writes to words 1, 3, 4 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| reg_addr | input | ADDR_W (5) | Word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
Two pairs of actions can fall in one cycle: a second strobe and a write-one-to-clear of the status bits, and a second strobe and a new staging write. The bench drives each pair in the same cycle. It judges the first pair by the status bits that survive: the fresh seconds event must stay set while the alarm bit, which has no new event, clears. It judges the second pair by checking that the count takes the older staged value and that the newer value arrives only at the following strobe. A behavioural model running alongside the design checks the read data and both interrupt lines on every clock.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  // word offsets (byte offset / 4)
  localparam int unsigned OFS_SET_WR  = 0;
  localparam int unsigned OFS_SET_RD  = 1;
  localparam int unsigned OFS_CAL_WR  = 2;
  localparam int unsigned OFS_CAL_RD  = 3;
  localparam int unsigned OFS_NOW     = 4;
  localparam int unsigned OFS_SUBTICK = 5;
  localparam int unsigned OFS_ALARM   = 6;
  localparam int unsigned OFS_STATUS  = 8;
  localparam int unsigned OFS_MASK    = 9;
  localparam int unsigned OFS_ENABLE  = 10;
  localparam int unsigned OFS_DISABLE = 11;
  localparam int unsigned OFS_CTRL    = 16;

  // event bit positions in status / mask
  localparam int unsigned EV_SEC   = 0;
  localparam int unsigned EV_ALARM = 1;
  localparam int unsigned EV_NUM   = 2;

  // stored control bits
  localparam int unsigned CTL_BATT_BIT = 31;
  localparam int unsigned CTL_OSC_BIT  = 24;
endpackage

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              set_we,
  input  logic [TIME_W-1:0] set_data,
  input  logic              alarm_we,
  input  logic [TIME_W-1:0] alarm_data,
  output logic [TIME_W-1:0] now_q,
  output logic [TIME_W-1:0] staged_q,
  output logic [TIME_W-1:0] alarm_q,
  output logic              alarm_hit
);
  logic              pend_q;
  logic [TIME_W-1:0] now_nxt;

  // value the count takes at this strobe
  assign now_nxt   = pend_q ? staged_q : now_q + TIME_W'(1);
  assign alarm_hit = tick && (now_nxt == alarm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q    <= '0;
      staged_q <= '0;
      alarm_q  <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (tick) now_q <= now_nxt;
      if (set_we) begin
        staged_q <= set_data;
        pend_q   <= 1'b1;
      end else if (tick) begin
        pend_q   <= 1'b0;
      end
      if (alarm_we) alarm_q <= alarm_data;
    end
  end

  // R4: a plain strobe advances the count by exactly one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(tick) && !$past(pend_q) |-> now_q == $past(now_q) + TIME_W'(1));
  // R2: no strobe, no change of the live count (staging writes included)
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(tick) |-> $stable(now_q));
  // R2: a pending value is what the strobe loads
  assert_stage_load_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(tick) && $past(pend_q) |-> now_q == $past(staged_q));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] event_in,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic         dis_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] irq_q
);
  for (genvar i = 0; i < N; i++) begin : g_ev
    logic sts_nxt, mask_nxt;

    always_comb begin
      sts_nxt  = (sts_q[i] && !(clr_we && wbits[i])) || event_in[i];
      mask_nxt = (mask_q[i] || (en_we && wbits[i])) && !(dis_we && wbits[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sts_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
        irq_q[i]  <= 1'b0;
      end else begin
        sts_q[i]  <= sts_nxt;
        mask_q[i] <= mask_nxt;
        irq_q[i]  <= sts_nxt && mask_nxt;
      end
    end

    // R5: an event always leaves its status bit set
    assert_event_sets_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(event_in[i]) |-> sts_q[i]);
    // R6: a set bit survives unless a one was written to clear it
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(sts_q[i]) && !$past(clr_we && wbits[i]) |-> sts_q[i]);
    // R7: enable write sets the mask bit
    assert_mask_set_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(en_we && wbits[i]) |-> mask_q[i]);
    // R7: disable write clears the mask bit
    assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(dis_we && wbits[i]) |-> !mask_q[i]);
    // R8: no line without both enable and status
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
      irq_q[i] |-> mask_q[i] && sts_q[i]);
  end
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CAL_W  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  localparam int unsigned NEV = EV_NUM;

  logic              we_set, we_alarm, we_cal, we_ctrl, we_sts, we_en, we_dis;
  logic [DATA_W-1:0] now_q, staged_q, alarm_q;
  logic              alarm_hit;
  logic [NEV-1:0]    events, sts_q, mask_q, irq_q;
  logic [CAL_W-1:0]  cal_q;
  logic              batt_q, osc_q;
  logic [DATA_W-1:0] rd_nxt;

  assign we_set   = reg_we && (reg_addr == ADDR_W'(OFS_SET_WR));
  assign we_cal   = reg_we && (reg_addr == ADDR_W'(OFS_CAL_WR));
  assign we_alarm = reg_we && (reg_addr == ADDR_W'(OFS_ALARM));
  assign we_sts   = reg_we && (reg_addr == ADDR_W'(OFS_STATUS));
  assign we_en    = reg_we && (reg_addr == ADDR_W'(OFS_ENABLE));
  assign we_dis   = reg_we && (reg_addr == ADDR_W'(OFS_DISABLE));
  assign we_ctrl  = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));

  rtc_sec_count #(.TIME_W(DATA_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .tick       (sec_tick),
    .set_we     (we_set),
    .set_data   (reg_wdata),
    .alarm_we   (we_alarm),
    .alarm_data (reg_wdata),
    .now_q      (now_q),
    .staged_q   (staged_q),
    .alarm_q    (alarm_q),
    .alarm_hit  (alarm_hit)
  );

  always_comb begin
    events           = '0;
    events[EV_SEC]   = sec_tick;
    events[EV_ALARM] = alarm_hit;
  end

  rtc_irq_ctrl #(.N(NEV)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .event_in (events),
    .clr_we   (we_sts),
    .en_we    (we_en),
    .dis_we   (we_dis),
    .wbits    (reg_wdata[NEV-1:0]),
    .sts_q    (sts_q),
    .mask_q   (mask_q),
    .irq_q    (irq_q)
  );

  assign irq_sec   = irq_q[EV_SEC];
  assign irq_alarm = irq_q[EV_ALARM];

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q  <= '0;
      batt_q <= 1'b0;
      osc_q  <= 1'b0;
    end else begin
      if (we_cal) cal_q <= reg_wdata[CAL_W-1:0];
      if (we_ctrl) begin
        batt_q <= reg_wdata[CTL_BATT_BIT];
        osc_q  <= reg_wdata[CTL_OSC_BIT];
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (reg_addr)
      ADDR_W'(OFS_SET_RD): rd_nxt = staged_q;
      ADDR_W'(OFS_CAL_RD): rd_nxt = DATA_W'(cal_q);
      ADDR_W'(OFS_NOW):    rd_nxt = now_q;
      ADDR_W'(OFS_ALARM):  rd_nxt = alarm_q;
      ADDR_W'(OFS_STATUS): rd_nxt = DATA_W'(sts_q);
      ADDR_W'(OFS_MASK):   rd_nxt = DATA_W'(mask_q);
      ADDR_W'(OFS_CTRL): begin
        rd_nxt[CTL_BATT_BIT] = batt_q;
        rd_nxt[CTL_OSC_BIT]  = osc_q;
      end
      default:             rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  // R10: the read-only sub-second word never returns data
  assert_subtick_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(reg_addr) == ADDR_W'(OFS_SUBTICK) |-> reg_rdata == '0);
  // R1: interrupt lines are low while the block is held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !irq_sec && !irq_alarm && reg_rdata == '0);
endmodule

// File: tb/sim_rtc_time_regs.sv
module sim_rtc_time_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_sec, irq_alarm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rtc_time_regs u0 (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  // behavioural reference
  logic [31:0] m_now, m_stg, m_alm, m_cal, m_ctl, m_rd, nxt;
  logic        m_pend;
  logic [1:0]  m_sts, m_msk, m_irq, ev;

  always @(posedge clk) begin
    if (rst) begin
      m_now = 0; m_stg = 0; m_alm = 0; m_cal = 0; m_ctl = 0; m_rd = 0;
      m_pend = 0; m_sts = 0; m_msk = 0; m_irq = 0;
    end else begin
      case (reg_addr)
        5'd1:    m_rd = m_stg;
        5'd3:    m_rd = m_cal;
        5'd4:    m_rd = m_now;
        5'd6:    m_rd = m_alm;
        5'd8:    m_rd = {30'd0, m_sts};
        5'd9:    m_rd = {30'd0, m_msk};
        5'd16:   m_rd = m_ctl;
        default: m_rd = 0;
      endcase
      nxt = m_pend ? m_stg : m_now + 32'd1;
      ev  = {sec_tick && (nxt == m_alm), sec_tick};
      if (sec_tick) begin m_now = nxt; m_pend = 0; end
      if (reg_we) begin
        case (reg_addr)
          5'd0:  begin m_stg = reg_wdata; m_pend = 1; end
          5'd2:  m_cal = reg_wdata & 32'h001F_FFFF;
          5'd6:  m_alm = reg_wdata;
          5'd8:  m_sts = m_sts & ~reg_wdata[1:0];
          5'd10: m_msk = m_msk | reg_wdata[1:0];
          5'd11: m_msk = m_msk & ~reg_wdata[1:0];
          5'd16: m_ctl = reg_wdata & 32'h8100_0000;
          default: ;
        endcase
      end
      m_sts = m_sts | ev;
      m_irq = m_sts & m_msk;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (reg_rdata !== m_rd) begin
        fails++;
        $display("FAIL R10 read data actual=%h expected=%h", reg_rdata, m_rd);
      end
      checks++;
      if ({irq_alarm, irq_sec} !== m_irq) begin
        fails++;
        $display("FAIL R8 irq lines actual=%b expected=%b", {irq_alarm, irq_sec}, m_irq);
      end
    end
  end

  task automatic cyc(input bit tk, input bit we, input int a, input logic [31:0] d);
    @(negedge clk);
    sec_tick = tk; reg_we = we; reg_addr = 5'(a); reg_wdata = d;
    @(posedge clk);
    #1;
    sec_tick = 0; reg_we = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    cyc(0, 0, a, 0);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 read data after reset", reg_rdata, 0);
    chk("R1 irq after reset", {30'd0, irq_alarm, irq_sec}, 0);
    @(negedge clk); rst = 0;
    rd(4, 0, "R1 time zero");
    rd(9, 0, "R1 mask zero");
    // staging
    cyc(0, 1, 0, 100);
    rd(4, 0, "R2 count unchanged before strobe");
    rd(1, 100, "R3 staged readback");
    cyc(1, 0, 0, 0);
    rd(4, 100, "R2 staged value loaded");
    cyc(1, 0, 0, 0);
    rd(4, 101, "R4 increment");
    rd(8, 1, "R5 seconds status");
    // mask and clear
    cyc(0, 1, 6, 103);
    cyc(0, 1, 10, 3);
    rd(9, 3, "R7 enable sets mask");
    chk("R8 irq_sec high", {31'd0, irq_sec}, 1);
    cyc(0, 1, 8, 1);
    chk("R6 cleared seconds irq", {31'd0, irq_sec}, 0);
    rd(8, 0, "R6 status cleared");
    cyc(1, 0, 0, 0);
    rd(8, 1, "R5 no alarm at 102");
    cyc(1, 0, 0, 0);
    chk("R8 irq_alarm high", {31'd0, irq_alarm}, 1);
    rd(8, 3, "R5 alarm status at 103");
    // strobe and clear in the same cycle
    cyc(1, 1, 8, 3);
    rd(8, 1, "R6 event wins over clear");
    cyc(0, 1, 11, 2);
    rd(9, 1, "R7 disable clears mask bit");
    // staging write on a strobe
    cyc(0, 1, 0, 500);
    cyc(1, 1, 0, 600);
    rd(4, 500, "R2 strobe loads older value");
    rd(1, 600, "R3 newer staged readback");
    cyc(1, 0, 0, 0);
    rd(4, 600, "R2 newer value at next strobe");
    // alarm reached via a load
    cyc(0, 1, 8, 3);
    cyc(0, 1, 6, 700);
    cyc(0, 1, 0, 700);
    cyc(1, 0, 0, 0);
    rd(8, 3, "R5 alarm on loaded time");
    // wrap
    cyc(0, 1, 0, 32'hFFFF_FFFF);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    rd(4, 0, "R4 wrap to zero");
    // storage registers
    cyc(0, 1, 2, 32'hFFFF_FFFF);
    rd(3, 32'h001F_FFFF, "R9 calibration width");
    rd(2, 0, "R10 calibration write word reads zero");
    cyc(0, 1, 16, 32'hFFFF_FFFF);
    rd(16, 32'h8100_0000, "R9 control bits");
    // ignored writes
    cyc(0, 1, 4, 55);
    cyc(0, 1, 5, 77);
    cyc(0, 1, 1, 88);
    rd(4, 0, "R10 write to count ignored");
    rd(5, 0, "R10 sub-second reads zero");
    rd(1, 32'hFFFF_FFFF, "R10 write to readback ignored");
    rd(0, 0, "R10 set word reads zero");
    rd(20, 0, "R10 unmapped reads zero");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule